// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the low-order address bits for a four-beat burst to a synchronous memory. When either of two address strobes is accepted, it captures the starting low bits. On each later clock where the advance input is high, it moves to the next beat. The upper address bits are handled elsewhere, and the block has no storage or data path.

The beat order depends on a mode input. In linear order, each step adds one to the address and wraps within the four-beat group. In interleaved order, the address for beat k is the starting address XOR k, so the order depends on where the burst started. A parameter can also fix the block to one of the two orders, which leaves the mode pin unused. A wrap flag goes high once the burst has gone through all its beats and come back to the start. The flag stays high until the next strobe.

Top module: `burst_seq_gen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, lsb_o reads 0 and wrapped_o reads 0.
- R2: A clock edge with strobe_cpu_i or strobe_ctl_i high loads start_lsb_i. From the next cycle on, lsb_o equals that start value and wrapped_o is 0.
- R3: A clock edge with both strobes and adv_i low leaves lsb_o and wrapped_o unchanged.
- R4: With mode_i = 0 (linear order), the k-th advance after a load gives lsb_o = (start + k) mod 4. For a start of 2 the sequence is 2, 3, 0, 1.
- R5: With mode_i = 1 (interleaved order), the k-th advance after a load gives lsb_o = start XOR (k mod 4). For a start of 1 the sequence is 1, 0, 3, 2.
- R6: The fourth advance after a load returns lsb_o to the start value and sets wrapped_o to 1. Further advances keep cycling through the same four values with wrapped_o held at 1.
- R7: A strobe in the middle of a burst reloads the start at once. If adv_i is high on the same edge, the strobe takes priority and wrapped_o clears.
- R8: Both strobes high on the same edge act exactly like a single strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_cpu_i | input | 1 | First address strobe; loads the start bits |
| strobe_ctl_i | input | 1 | Second address strobe; loads the start bits |
| adv_i | input | 1 | Step to the next beat |
| mode_i | input | 1 | Beat order: 0 = linear, 1 = interleaved |
| start_lsb_i | input | LSB_W | Low-order start address bits |
| lsb_o | output | LSB_W | Current low-order address bits |
| wrapped_o | output | 1 | Burst has gone through all beats and wrapped |

## Verification
The beat index and the captured start value are internal registers. Either one being wrong shows on lsb_o on the very next cycle after the edge that corrupted it. A stuck or skipped beat breaks the expected linear or XOR sequence within one advance. A wrap flag that sets on the wrong beat differs from the expected value on the fourth advance. A flag that a strobe fails to clear shows on the first cycle after the reload.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
   // Selection of the beat order built into the mapper
   localparam int ORD_RUNTIME    = 0;   // mode pin chooses
   localparam int ORD_LINEAR     = 1;   // fixed linear
   localparam int ORD_INTERLEAVE = 2;   // fixed interleaved

   typedef enum logic {
      SEQ_LINEAR     = 1'b0,
      SEQ_INTERLEAVE = 1'b1
   } seq_mode_e;

   // Resolve the active order from the build option and the pin
   function automatic seq_mode_e resolve_mode(input int sel, input logic pin);
      if (sel == ORD_LINEAR)
         return SEQ_LINEAR;
      else if (sel == ORD_INTERLEAVE)
         return SEQ_INTERLEAVE;
      else
         return pin ? SEQ_INTERLEAVE : SEQ_LINEAR;
   endfunction
endpackage

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
   parameter int LSB_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [LSB_W-1:0] start_i,
   output logic [LSB_W-1:0] base_o
);
   initial begin
      assert (LSB_W >= 1) else $fatal(1, "burst_base_reg: LSB_W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         base_o <= '0;
      else if (load_i)
         base_o <= start_i;
   end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
   parameter int LSB_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             adv_i,
   output logic [LSB_W-1:0] beat_o,
   output logic             wrap_o
);
   localparam logic [LSB_W-1:0] LAST_BEAT = {LSB_W{1'b1}};

   logic last_step;

   initial begin
      assert (LSB_W >= 1) else $fatal(1, "burst_beat_ctr: LSB_W must be positive");
   end

   assign last_step = adv_i && (beat_o == LAST_BEAT);

   // A load has priority over an advance on the same edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beat_o <= '0;
         wrap_o <= 1'b0;
      end else if (load_i) begin
         beat_o <= '0;
         wrap_o <= 1'b0;
      end else if (adv_i) begin
         beat_o <= beat_o + 1'b1;
         if (last_step)
            wrap_o <= 1'b1;
      end
   end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
   import burst_seq_pkg::*;
#(
   parameter int LSB_W     = 2,
   parameter int ORDER_SEL = ORD_RUNTIME
) (
   input  logic             mode_i,
   input  logic [LSB_W-1:0] base_i,
   input  logic [LSB_W-1:0] beat_i,
   output logic [LSB_W-1:0] addr_o
);
   initial begin
      assert (ORDER_SEL >= ORD_RUNTIME && ORDER_SEL <= ORD_INTERLEAVE)
         else $fatal(1, "burst_order_map: bad ORDER_SEL");
   end

   generate
      if (ORDER_SEL == ORD_RUNTIME) begin : g_runtime
         seq_mode_e eff;
         always_comb begin
            eff = resolve_mode(ORDER_SEL, mode_i);
            if (eff == SEQ_INTERLEAVE)
               addr_o = base_i ^ beat_i;
            else
               addr_o = base_i + beat_i;
         end
      end else if (ORDER_SEL == ORD_LINEAR) begin : g_linear
         logic unused_mode;
         assign unused_mode = mode_i;
         assign addr_o = base_i + beat_i;
      end else begin : g_interleave
         logic unused_mode;
         assign unused_mode = mode_i;
         assign addr_o = base_i ^ beat_i;
      end
   endgenerate
endmodule

// File: rtl/burst_seq_gen.sv
module burst_seq_gen
   import burst_seq_pkg::*;
#(
   parameter int LSB_W     = 2,
   parameter int ORDER_SEL = ORD_RUNTIME
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strobe_cpu_i,
   input  logic             strobe_ctl_i,
   input  logic             adv_i,
   input  logic             mode_i,
   input  logic [LSB_W-1:0] start_lsb_i,
   output logic [LSB_W-1:0] lsb_o,
   output logic             wrapped_o
);
   logic             load;
   logic [LSB_W-1:0] base;
   logic [LSB_W-1:0] beat;

   initial begin
      assert (LSB_W >= 1 && LSB_W <= 4)
         else $fatal(1, "burst_seq_gen: LSB_W must be 1..4");
   end

   assign load = strobe_cpu_i | strobe_ctl_i;

   burst_base_reg #(.LSB_W(LSB_W)) u_base (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load),
      .start_i(start_lsb_i),
      .base_o (base)
   );

   burst_beat_ctr #(.LSB_W(LSB_W)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load),
      .adv_i  (adv_i),
      .beat_o (beat),
      .wrap_o (wrapped_o)
   );

   burst_order_map #(.LSB_W(LSB_W), .ORDER_SEL(ORDER_SEL)) u_map (
      .mode_i (mode_i),
      .base_i (base),
      .beat_i (beat),
      .addr_o (lsb_o)
   );
endmodule

// File: rtl/burst_seq_gen_chk.sv
module burst_seq_gen_chk
   import burst_seq_pkg::*;
#(
   parameter int LSB_W     = 2,
   parameter int ORDER_SEL = ORD_RUNTIME
) (
   input logic             clk,
   input logic             rst_n,
   input logic             strobe_cpu_i,
   input logic             strobe_ctl_i,
   input logic             adv_i,
   input logic             mode_i,
   input logic [LSB_W-1:0] start_lsb_i,
   input logic [LSB_W-1:0] lsb_o,
   input logic             wrapped_o
);
   logic any_strobe;
   logic lin_active;

   assign any_strobe = strobe_cpu_i | strobe_ctl_i;
   assign lin_active = (resolve_mode(ORDER_SEL, mode_i) == SEQ_LINEAR);

   AST_RESET_CLEAR: assert property (@(posedge clk)
      !rst_n |=> (lsb_o == '0 && !wrapped_o));                                  // R1
   AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
      any_strobe |=> (lsb_o == $past(start_lsb_i)));                            // R2
   AST_LOAD_CLEARS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      any_strobe |=> !wrapped_o);                                               // R7
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_strobe && !adv_i) |=> ($stable(lsb_o) && $stable(wrapped_o)));      // R3
   AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_strobe && adv_i && lin_active) |=>
         (lsb_o == LSB_W'($past(lsb_o) + 1'b1)));                               // R4
   AST_WRAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (wrapped_o && !any_strobe) |=> wrapped_o);                                // R6
endmodule

bind burst_seq_gen burst_seq_gen_chk #(.LSB_W(LSB_W), .ORDER_SEL(ORDER_SEL)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .strobe_cpu_i(strobe_cpu_i),
   .strobe_ctl_i(strobe_ctl_i),
   .adv_i       (adv_i),
   .mode_i      (mode_i),
   .start_lsb_i (start_lsb_i),
   .lsb_o       (lsb_o),
   .wrapped_o   (wrapped_o)
);

// File: tb/burst_seq_gen_tb.sv
module burst_seq_gen_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       s_cpu = 1'b0;
   logic       s_ctl = 1'b0;
   logic       adv = 1'b0;
   logic       mode = 1'b0;
   logic [1:0] start = 2'd0;
   logic [1:0] lsb;
   logic       wrp;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   burst_seq_gen u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .strobe_cpu_i(s_cpu),
      .strobe_ctl_i(s_ctl),
      .adv_i       (adv),
      .mode_i      (mode),
      .start_lsb_i (start),
      .lsb_o       (lsb),
      .wrapped_o   (wrp)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one clock edge, then sample 1 ns later
   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic idle();
      s_cpu = 0; s_ctl = 0; adv = 0;
   endtask

   task automatic load(input logic [1:0] st, input bit cpu, input bit ctl);
      s_cpu = cpu; s_ctl = ctl; adv = 0; start = st;
      step();
      idle();
   endtask

   task automatic t_reset();
      rst_n = 0;
      idle();
      step();
      chk("R1 lsb in reset", lsb, 0);
      chk("R1 wrap in reset", wrp, 0);
      rst_n = 1;
      step();
      chk("R1 lsb after release", lsb, 0);
      chk("R1 wrap after release", wrp, 0);
   endtask

   task automatic t_burst(input bit inter, input logic [1:0] st);
      mode = inter;
      load(st, 1, 0);
      chk(inter ? "R2 load (interleaved)" : "R2 load (linear)", lsb, st);
      chk("R2 wrap cleared on load", wrp, 0);
      for (int k = 1; k <= 6; k++) begin
         int exp;
         adv = 1;
         step();
         adv = 0;
         exp = inter ? (st ^ (k % 4)) : ((st + k) % 4);
         chk(inter ? "R5 interleaved beat" : "R4 linear beat", lsb, exp);
         chk("R6 wrap flag", wrp, (k >= 4) ? 1 : 0);
      end
   endtask

   task automatic t_hold();
      mode = 1;
      load(2'd2, 0, 1);
      adv = 1; step(); adv = 0;
      chk("R5 first step from 2", lsb, 3);
      for (int i = 0; i < 3; i++) begin
         start = 2'(i);
         step();
         chk("R3 idle holds lsb", lsb, 3);
         chk("R3 idle holds wrap", wrp, 0);
      end
      adv = 1; step(); adv = 0;
      chk("R5 resumes after hold", lsb, 0);
   endtask

   task automatic t_reload();
      mode = 0;
      load(2'd1, 1, 0);
      adv = 1; step();
      chk("R4 step before reload", lsb, 2);
      s_ctl = 1; start = 2'd3;       // adv still high
      step();
      idle();
      chk("R7 reload beats advance", lsb, 3);
      adv = 1; step(); adv = 0;
      chk("R7 burst restarts from new start", lsb, 0);
      for (int k = 0; k < 3; k++) begin
         adv = 1; step(); adv = 0;
      end
      chk("R6 wrap after full reload burst", wrp, 1);
      chk("R6 lsb back at start", lsb, 3);
      s_cpu = 1; adv = 1; start = 2'd0;
      step();
      idle();
      chk("R7 strobe clears wrap", wrp, 0);
      chk("R7 strobe loads over advance", lsb, 0);
   endtask

   task automatic t_dual();
      mode = 1;
      load(2'd1, 1, 1);
      chk("R8 dual strobe load", lsb, 1);
      chk("R8 dual strobe wrap", wrp, 0);
      adv = 1; step(); adv = 0;
      chk("R8 step after dual strobe", lsb, 0);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_burst(0, 2'd2);
      t_burst(0, 2'd3);
      t_burst(1, 2'd1);
      t_burst(1, 2'd2);
      t_burst(1, 2'd3);
      t_hold();
      t_reload();
      t_dual();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule